// File: doc/BRIEF.md
# Atomic Bit-Clear Memory Unit

This unit executes one read-modify-write instruction: it reads a 32-bit or 64-bit word from memory, clears every bit that is set in an operand register, writes the result back, and hands the unmodified original word to a register writeback port. The unit decodes the 32-bit instruction word itself. It drives the source and base register indexes to a register-file read port, takes the stack pointer as a separate input, and checks alignment before it issues any memory traffic.

A caller presents the instruction on `instr_i` and pulses `start_i` while the unit is idle. In that same cycle the operand and base register values must be valid on `rs_data_i` and `rn_data_i`. The unit then holds `mem_lock_o` high from its read request through its write response, so the memory sees the two accesses as one indivisible operation. Each access carries an ordering qualifier: acquire on the read and release on the write. A one-cycle `done_o` pulse ends every accepted command. `fault_o` and `illegal_o` qualify that pulse.

Top module: `atomic_bitclr_unit`

## Requirements
- R1: An instruction word matches only if bit 31 is 1, bits 29:24 are 111000, bit 21 is 1 and bits 15:10 are 000100. Bit 30 selects the size (1 = 64-bit, 0 = 32-bit). A non-matching word produces `done_o` and `illegal_o` one cycle after start, with no memory request and no writeback.
- R2: A valid command issues exactly one read (`mem_we_o`=0) followed by exactly one write (`mem_we_o`=1) to the same address. `mem_lock_o` is high from the read request through the write response. A request is held stable until `mem_ready_i` is sampled high, and each access completes on a later `mem_rvalid_i`.
- R3: The write data is the loaded value ANDed with the complement of the operand. 32-bit data sits on bits 31:0 of the data buses, and the upper 32 bits of the written value are zero. `mem_wide_o` is 1 for 64-bit accesses.
- R4: When Rt (bits 4:0) is not 31, `wb_valid_o` is high together with `done_o`, with `wb_idx_o` = Rt and `wb_data_o` = the pre-modification value, zero-extended. When Rt is 31 there is no writeback.
- R5: `mem_acq_o` is high on the read request only when bit 23 (A) is 1 and Rt is not 31. It is never high on the write.
- R6: `mem_rel_o` is high on the write request exactly when bit 22 (R) is 1. It is never high on the read.
- R7: `rs_idx_o` shows bits 20:16 and `rn_idx_o` shows bits 9:5 of `instr_i` in the same cycle. The access address is `sp_i` when Rn is 31 and `rn_data_i` otherwise.
- R8: When Rn is 31 and `sp_i` is not a multiple of 16, the command ends with `fault_o` and `done_o` one cycle after start, with no memory access.
- R9: An address that is not a multiple of the access size (4 or 8 bytes) raises `fault_o` with `done_o` and issues no memory access.
- R10: `done_o` is a one-cycle pulse and occurs in the cycle after the cycle in which the write response is sampled.
- R11: `alias_o` is high with `done_o` for a matching word with A = 0 and Rt = 31 (store-only form), and low otherwise.
- R12: `start_i` is ignored while `busy_o` is high. A command accepted from idle raises `busy_o` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a command (sampled when idle) |
| instr_i | input | 32 | Instruction word |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| fault_o | output | 1 | Alignment fault, valid with done_o |
| illegal_o | output | 1 | Instruction did not match, valid with done_o |
| alias_o | output | 1 | Store-only form, valid with done_o |
| rs_idx_o | output | 5 | Operand register index |
| rn_idx_o | output | 5 | Base register index |
| rs_data_i | input | 64 | Operand register value |
| rn_data_i | input | 64 | Base register value |
| sp_i | input | 64 | Stack pointer value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_lock_o | output | 1 | Atomic lock held |
| mem_acq_o | output | 1 | Acquire qualifier |
| mem_rel_o | output | 1 | Release qualifier |
| mem_wide_o | output | 1 | 64-bit access when 1 |
| mem_addr_o | output | 64 | Access address |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | 64 | Read data |
| wb_valid_o | output | 1 | Writeback valid |
| wb_idx_o | output | 5 | Writeback register index |
| wb_data_o | output | 64 | Writeback value (old memory word) |

## Verification
The clear operation runs on 64-bit words and on both 32-bit halves of a doubleword. The operands are chosen so that a 32-bit command also carries set bits in the operand's upper half, which separates correct truncation from plain 64-bit masking. All-ones and all-zero operands show whether the complement is taken and whether the old word, rather than the result, is written back. Commands sweep the A and R bits against Rt equal to and not equal to 31, which separates the acquire-drop rule, the release rule, the writeback rule and the store-only flag. Base values that are aligned, 4-but-not-8 aligned, and 8-but-not-16 aligned through the stack pointer separate the natural-alignment fault from the stack-pointer fault. Memory wait states and a start pulse issued mid-command test request stability and command isolation.

// File: rtl/aclr_pkg.sv
package aclr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ,
    ST_WR_WAIT,
    ST_FIN
  } aclr_state_e;

  typedef struct packed {
    logic       match;
    logic       wide;
    logic       acq;
    logic       rel;
    logic       alias_st;
    logic       wb_en;
    logic       use_sp;
    logic [4:0] rs;
    logic [4:0] rn;
    logic [4:0] rt;
  } aclr_dec_t;
endpackage

// File: rtl/aclr_decode.sv
module aclr_decode
  import aclr_pkg::*;
(
  input  logic [31:0] instr_i,
  output aclr_dec_t   dec_o
);
  localparam logic [5:0] FIX_HI  = 6'b111000;
  localparam logic [5:0] FIX_MID = 6'b000100;
  localparam logic [4:0] ZERO_REG = 5'd31;

  logic rt_zero;
  logic hit;

  assign rt_zero = (instr_i[4:0] == ZERO_REG);
  assign hit = instr_i[31] && (instr_i[29:24] == FIX_HI) && instr_i[21] &&
               (instr_i[15:10] == FIX_MID);

  always_comb begin
    dec_o.match    = hit;
    dec_o.wide     = instr_i[30];
    dec_o.acq      = instr_i[23] && !rt_zero;  // acquire dropped for zero destination
    dec_o.rel      = instr_i[22];
    dec_o.alias_st = hit && !instr_i[23] && rt_zero;
    dec_o.wb_en    = !rt_zero;
    dec_o.use_sp   = (instr_i[9:5] == ZERO_REG);
    dec_o.rs       = instr_i[20:16];
    dec_o.rn       = instr_i[9:5];
    dec_o.rt       = instr_i[4:0];
  end
endmodule

// File: rtl/aclr_addr_chk.sv
module aclr_addr_chk #(
  parameter int ADDR_W       = 64,
  parameter int SP_ALIGN     = 16,
  parameter int NARROW_BYTES = 4,
  parameter int WIDE_BYTES   = 8
) (
  input  logic              use_sp_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sp_fault_o,
  output logic              nat_fault_o
);
  localparam int SP_LSB = $clog2(SP_ALIGN);
  localparam int N_LSB  = $clog2(NARROW_BYTES);
  localparam int W_LSB  = $clog2(WIDE_BYTES);

  assign addr_o = use_sp_i ? sp_i : base_i;

  generate
    if (SP_LSB == 0) begin : g_no_sp_chk
      assign sp_fault_o = 1'b0;
    end else begin : g_sp_chk
      assign sp_fault_o = use_sp_i && (|sp_i[SP_LSB-1:0]);
    end
  endgenerate

  assign nat_fault_o = wide_i ? (|addr_o[W_LSB-1:0]) : (|addr_o[N_LSB-1:0]);
endmodule

// File: rtl/aclr_seq.sv
module aclr_seq
  import aclr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              match_i,
  input  logic              wide_i,
  input  logic              acq_i,
  input  logic              rel_i,
  input  logic              alias_i,
  input  logic              wb_en_i,
  input  logic [4:0]        rt_i,
  input  logic              sp_fault_i,
  input  logic              nat_fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rs_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              illegal_o,
  output logic              alias_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic              mem_acq_o,
  output logic              mem_rel_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic [4:0]        wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int HALF_W = DATA_W / 2;

  aclr_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, old_q;
  logic wide_q, acq_q, rel_q, wb_en_q, alias_q, fault_q, illegal_q;
  logic [4:0] rt_q;
  logic accept, bad;

  function automatic logic [DATA_W-1:0] fit(input logic [DATA_W-1:0] v, input logic wide);
    fit = wide ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  assign accept = (state_q == ST_IDLE) && start_i;
  assign bad    = !match_i || sp_fault_i || nat_fault_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = bad ? ST_FIN : ST_RD_REQ;
      ST_RD_REQ:  if (mem_ready_i) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mem_rvalid_i) state_d = ST_WR_REQ;
      ST_WR_REQ:  if (mem_ready_i) state_d = ST_WR_WAIT;
      ST_WR_WAIT: if (mem_rvalid_i) state_d = ST_FIN;
      ST_FIN:     state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      opnd_q    <= '0;
      old_q     <= '0;
      wide_q    <= 1'b0;
      acq_q     <= 1'b0;
      rel_q     <= 1'b0;
      wb_en_q   <= 1'b0;
      alias_q   <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
      rt_q      <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q    <= addr_i;
        opnd_q    <= fit(rs_data_i, wide_i);
        wide_q    <= wide_i;
        acq_q     <= acq_i;
        rel_q     <= rel_i;
        wb_en_q   <= wb_en_i;
        alias_q   <= alias_i;
        rt_q      <= rt_i;
        illegal_q <= !match_i;
        fault_q   <= match_i && (sp_fault_i || nat_fault_i);
      end
      if ((state_q == ST_RD_WAIT) && mem_rvalid_i) old_q <= fit(mem_rdata_i, wide_q);
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign fault_o     = done_o && fault_q;
  assign illegal_o   = done_o && illegal_q;
  assign alias_o     = done_o && alias_q && !illegal_q;
  assign mem_req_o   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we_o    = (state_q == ST_WR_REQ);
  assign mem_lock_o  = (state_q == ST_RD_REQ) || (state_q == ST_RD_WAIT) ||
                       (state_q == ST_WR_REQ) || (state_q == ST_WR_WAIT);
  assign mem_acq_o   = (state_q == ST_RD_REQ) && acq_q;
  assign mem_rel_o   = (state_q == ST_WR_REQ) && rel_q;
  assign mem_wide_o  = wide_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = old_q & ~opnd_q;
  assign wb_valid_o  = done_o && wb_en_q && !fault_q && !illegal_q;
  assign wb_idx_o    = rt_q;
  assign wb_data_o   = old_q;

  p_req_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_lock_o);
  p_req_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  p_acq_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_acq_o |-> (mem_req_o && !mem_we_o));
  p_rel_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rel_o |-> (mem_req_o && mem_we_o));
  p_wb_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o);
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_illegal_nowb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_valid_o && !fault_o));
  p_busy_start_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/atomic_bitclr_unit.sv
module atomic_bitclr_unit
  import aclr_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int SP_ALIGN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [31:0]       instr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              illegal_o,
  output logic              alias_o,
  output logic [4:0]        rs_idx_o,
  output logic [4:0]        rn_idx_o,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic [ADDR_W-1:0] rn_data_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic              mem_acq_o,
  output logic              mem_rel_o,
  output logic              mem_wide_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic [4:0]        wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  localparam int NARROW_BYTES = DATA_W / 16;
  localparam int WIDE_BYTES   = DATA_W / 8;

  aclr_dec_t         dec;
  logic [ADDR_W-1:0] addr;
  logic              sp_fault, nat_fault;

  aclr_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  // R7: register-file read indexes follow the instruction word directly
  assign rs_idx_o = dec.rs;
  assign rn_idx_o = dec.rn;

  aclr_addr_chk #(
    .ADDR_W       (ADDR_W),
    .SP_ALIGN     (SP_ALIGN),
    .NARROW_BYTES (NARROW_BYTES),
    .WIDE_BYTES   (WIDE_BYTES)
  ) u_chk (
    .use_sp_i    (dec.use_sp),
    .wide_i      (dec.wide),
    .sp_i        (sp_i),
    .base_i      (rn_data_i),
    .addr_o      (addr),
    .sp_fault_o  (sp_fault),
    .nat_fault_o (nat_fault)
  );

  aclr_seq #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .match_i      (dec.match),
    .wide_i       (dec.wide),
    .acq_i        (dec.acq),
    .rel_i        (dec.rel),
    .alias_i      (dec.alias_st),
    .wb_en_i      (dec.wb_en),
    .rt_i         (dec.rt),
    .sp_fault_i   (sp_fault),
    .nat_fault_i  (nat_fault),
    .addr_i       (addr),
    .rs_data_i    (rs_data_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o),
    .illegal_o    (illegal_o),
    .alias_o      (alias_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_lock_o   (mem_lock_o),
    .mem_acq_o    (mem_acq_o),
    .mem_rel_o    (mem_rel_o),
    .mem_wide_o   (mem_wide_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .wb_valid_o   (wb_valid_o),
    .wb_idx_o     (wb_idx_o),
    .wb_data_o    (wb_data_o)
  );
endmodule

// File: tb/sim_atomic_bitclr_unit.sv
module sim_atomic_bitclr_unit;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] rs_data_i = '0, rn_data_i = '0, sp_i = '0;
  logic        mem_ready_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic busy_o, done_o, fault_o, illegal_o, alias_o;
  logic [4:0] rs_idx_o, rn_idx_o, wb_idx_o;
  logic mem_req_o, mem_we_o, mem_lock_o, mem_acq_o, mem_rel_o, mem_wide_o, wb_valid_o;
  logic [63:0] mem_addr_o, mem_wdata_o, wb_data_o;

  atomic_bitclr_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .instr_i(instr_i),
    .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .illegal_o(illegal_o),
    .alias_o(alias_o), .rs_idx_o(rs_idx_o), .rn_idx_o(rn_idx_o),
    .rs_data_i(rs_data_i), .rn_data_i(rn_data_i), .sp_i(sp_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_lock_o(mem_lock_o),
    .mem_acq_o(mem_acq_o), .mem_rel_o(mem_rel_o), .mem_wide_o(mem_wide_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .wb_valid_o(wb_valid_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o)
  );

  typedef struct packed {
    logic        fault;
    logic        illegal;
    logic        alias_f;
    logic        wbv;
    logic [4:0]  wbi;
    logic [63:0] wbd;
    logic        acq;
    logic        rel;
    logic        wide;
    logic [63:0] addr;
    logic [63:0] wdata;
  } exp_t;

  exp_t q[$];
  logic [63:0] mem [0:31];
  int checks = 0;
  int errors = 0;
  int wait_cfg = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sz, input bit a, input bit r,
                                     input logic [4:0] rs, input logic [4:0] rn,
                                     input logic [4:0] rt);
    return {sz, 6'b111000, a, r, 1'b1, rs, 6'b000100, rn, rt};
  endfunction

  // memory model + monitor, all at the falling edge
  initial begin : model
    bit acc_pend, acc_we, acc_wide, in_at, wr_resp_prev, lock_bad;
    logic [63:0] acc_addr, acc_wdata, rd_addr, wr_addr, wr_data;
    bit rd_acq, rd_rel, wr_acq, wr_rel, rd_wide;
    int waitc, n_acc;
    logic [4:0] ix;
    acc_pend = 0; acc_we = 0; acc_wide = 0; in_at = 0; wr_resp_prev = 0; lock_bad = 0;
    acc_addr = '0; acc_wdata = '0; rd_addr = '0; wr_addr = '0; wr_data = '0;
    rd_acq = 0; rd_rel = 0; wr_acq = 0; wr_rel = 0; rd_wide = 0; waitc = 0; n_acc = 0;
    forever begin
      @(negedge clk);
      if (rst_ni && done_o) begin
        if (q.size() == 0) begin
          chk(0, "R12", "done without command", 1, 0);
        end else begin
          exp_t e;
          bit ok;
          e = q.pop_front();
          ok = !e.fault && !e.illegal;
          chk(illegal_o == e.illegal, "R1", "illegal_o", 64'(illegal_o), 64'(e.illegal));
          chk(fault_o == e.fault, "R9", "fault_o", 64'(fault_o), 64'(e.fault));
          chk(alias_o == e.alias_f, "R11", "alias_o", 64'(alias_o), 64'(e.alias_f));
          chk(wb_valid_o == e.wbv, "R4", "wb_valid_o", 64'(wb_valid_o), 64'(e.wbv));
          if (e.wbv) begin
            chk(wb_idx_o == e.wbi, "R4", "wb_idx_o", 64'(wb_idx_o), 64'(e.wbi));
            chk(wb_data_o == e.wbd, "R4", "wb_data_o", wb_data_o, e.wbd);
          end
          chk(n_acc == (ok ? 2 : 0), "R2", "access count", 64'(n_acc), ok ? 64'd2 : 64'd0);
          if (ok) begin
            chk(rd_addr == e.addr, "R7", "read address", rd_addr, e.addr);
            chk(wr_addr == e.addr, "R2", "write address", wr_addr, e.addr);
            chk(wr_data == e.wdata, "R3", "write data", wr_data, e.wdata);
            chk(rd_wide == e.wide, "R3", "access width", 64'(rd_wide), 64'(e.wide));
            chk(rd_acq == e.acq, "R5", "read acquire", 64'(rd_acq), 64'(e.acq));
            chk(wr_acq == 0, "R5", "write acquire", 64'(wr_acq), 0);
            chk(wr_rel == e.rel, "R6", "write release", 64'(wr_rel), 64'(e.rel));
            chk(rd_rel == 0, "R6", "read release", 64'(rd_rel), 0);
            chk(wr_resp_prev, "R10", "done follows write response", 64'(wr_resp_prev), 1);
            chk(!lock_bad, "R2", "lock held", 64'(lock_bad), 0);
          end
        end
        n_acc = 0; lock_bad = 0;
      end
      // response phase
      mem_rvalid_i = 1'b0;
      wr_resp_prev = 0;
      if (in_at && !mem_lock_o) lock_bad = 1;
      if (acc_pend) begin
        acc_pend = 0;
        mem_rvalid_i = 1'b1;
        ix = acc_addr[7:3];
        if (acc_we) begin
          if (acc_wide) mem[ix] = acc_wdata;
          else if (acc_addr[2]) mem[ix][63:32] = acc_wdata[31:0];
          else mem[ix][31:0] = acc_wdata[31:0];
          wr_resp_prev = 1;
          in_at = 0;
        end else begin
          mem_rdata_i = acc_wide ? mem[ix] :
                        (acc_addr[2] ? {32'h0, mem[ix][63:32]} : {32'h0, mem[ix][31:0]});
        end
      end
      // request phase
      mem_ready_i = 1'b0;
      if (mem_req_o) begin
        if (waitc >= wait_cfg) begin
          mem_ready_i = 1'b1;
          acc_pend = 1;
          acc_we = mem_we_o; acc_addr = mem_addr_o; acc_wdata = mem_wdata_o;
          acc_wide = mem_wide_o;
          waitc = 0;
          n_acc++;
          if (!mem_lock_o) lock_bad = 1;
          if (mem_we_o) begin
            wr_addr = mem_addr_o; wr_data = mem_wdata_o; wr_acq = mem_acq_o; wr_rel = mem_rel_o;
          end else begin
            rd_addr = mem_addr_o; rd_acq = mem_acq_o; rd_rel = mem_rel_o; rd_wide = mem_wide_o;
            in_at = 1;
          end
        end else begin
          waitc++;
        end
      end
    end
  end

  // driver: predicts the result, queues it, runs the command
  task automatic run_op(input logic [31:0] ins, input logic [63:0] rsv, input logic [63:0] rnv,
                        input logic [63:0] spv, input bit poke);
    exp_t e;
    logic [63:0] base, old, neww, expword;
    logic [4:0] ix;
    bit match, wide, ok;
    match = ins[31] && (ins[29:24] == 6'b111000) && ins[21] && (ins[15:10] == 6'b000100);
    wide  = ins[30];
    base  = (ins[9:5] == 5'd31) ? spv : rnv;
    e = '0;
    e.illegal = !match;
    e.fault = match && (((ins[9:5] == 5'd31) && (spv[3:0] != 0)) ||
                        (wide ? (base[2:0] != 0) : (base[1:0] != 0)));
    ok = match && !e.fault;
    e.alias_f = match && !ins[23] && (ins[4:0] == 5'd31);
    e.wbv = ok && (ins[4:0] != 5'd31);
    e.wbi = ins[4:0];
    ix = base[7:3];
    old = wide ? mem[ix] : (base[2] ? {32'h0, mem[ix][63:32]} : {32'h0, mem[ix][31:0]});
    neww = old & ~(wide ? rsv : {32'h0, rsv[31:0]});
    e.wbd = old; e.acq = ins[23] && (ins[4:0] != 5'd31); e.rel = ins[22];
    e.wide = wide; e.addr = base; e.wdata = neww;
    expword = mem[ix];
    if (ok) begin
      if (wide) expword = neww;
      else if (base[2]) expword[63:32] = neww[31:0];
      else expword[31:0] = neww[31:0];
    end
    q.push_back(e);
    @(negedge clk);
    instr_i = ins; rs_data_i = rsv; rn_data_i = rnv; sp_i = spv; start_i = 1'b1;
    #1;
    chk(rs_idx_o == ins[20:16], "R7", "rs_idx_o", 64'(rs_idx_o), 64'(ins[20:16]));
    chk(rn_idx_o == ins[9:5], "R7", "rn_idx_o", 64'(rn_idx_o), 64'(ins[9:5]));
    @(negedge clk);
    start_i = 1'b0;
    if (!ok) begin
      // R8 / R1: outcome one cycle after start
      chk(done_o == 1'b1, e.illegal ? "R1" : "R8", "early done_o", 64'(done_o), 1);
    end else begin
      chk(busy_o == 1'b1, "R12", "busy after start", 64'(busy_o), 1);
    end
    if (poke) begin
      instr_i = mk(2'b11, 1'b0, 1'b0, 5'd1, 5'd1, 5'd1);
      rn_data_i = 64'h60;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(mem[ix] == expword, ok ? "R3" : "R9", "memory word", mem[ix], expword);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 32; i++) mem[i] = 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_0000_2222_0003);
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !mem_lock_o && !wb_valid_o, "R2", "reset outputs",
        {59'h0, busy_o, done_o, mem_req_o, mem_lock_o, wb_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R12", "idle after reset", {62'h0, busy_o, done_o}, 0);

    // R3 R4: 64-bit plain clear
    run_op(mk(2'b11, 0, 0, 5'd2, 5'd5, 5'd3), 64'h00FF_00FF_F0F0_0F0F, 64'h40, 64'h0, 0);
    // R5: 32-bit low half, acquire, operand upper bits must not leak
    run_op(mk(2'b10, 1, 0, 5'd4, 5'd6, 5'd7), 64'hFFFF_FFFF_0000_00F0, 64'h48, 64'h0, 0);
    // R5 R6 R4: 32-bit upper half, acquire dropped for Rt=31, release kept
    run_op(mk(2'b10, 1, 1, 5'd4, 5'd6, 5'd31), 64'h0000_0000_FF00_0001, 64'h4C, 64'h0, 0);
    // R11: store-only form with release
    run_op(mk(2'b11, 0, 1, 5'd1, 5'd2, 5'd31), 64'hAAAA_0000_0000_5555, 64'h50, 64'h0, 0);
    // R7 R2: stack pointer base, memory wait states, misaligned Rn value ignored
    wait_cfg = 2;
    run_op(mk(2'b11, 1, 1, 5'd9, 5'd31, 5'd12), 64'h0F0F_0F0F_0F0F_0F0F, 64'h13, 64'h80, 0);
    wait_cfg = 0;
    // R8: stack pointer not 16-byte aligned (64-bit and 32-bit)
    run_op(mk(2'b11, 0, 0, 5'd9, 5'd31, 5'd12), 64'h1, 64'h40, 64'h88, 0);
    run_op(mk(2'b10, 0, 0, 5'd9, 5'd31, 5'd12), 64'h1, 64'h40, 64'h84, 0);
    // R9: natural alignment faults
    run_op(mk(2'b11, 0, 0, 5'd3, 5'd5, 5'd4), 64'h1, 64'h44, 64'h0, 0);
    run_op(mk(2'b10, 0, 0, 5'd3, 5'd5, 5'd4), 64'h1, 64'h42, 64'h0, 0);
    // R1: non-matching words
    run_op({2'b01, mk(2'b11, 0, 0, 5'd3, 5'd5, 5'd4)}[31:0] & 32'h7FFF_FFFF, 64'h1, 64'h40, 64'h0, 0);
    run_op(mk(2'b11, 0, 0, 5'd3, 5'd5, 5'd4) & ~32'h0020_0000, 64'h1, 64'h40, 64'h0, 0);
    run_op(mk(2'b11, 0, 0, 5'd3, 5'd5, 5'd4) ^ 32'h0000_0400, 64'h1, 64'h40, 64'h0, 0);
    // R3: all-ones operand clears, zero operand keeps
    run_op(mk(2'b11, 0, 0, 5'd8, 5'd5, 5'd6), 64'hFFFF_FFFF_FFFF_FFFF, 64'h58, 64'h0, 0);
    run_op(mk(2'b11, 0, 0, 5'd8, 5'd5, 5'd6), 64'h0, 64'h60, 64'h0, 0);
    // R12: start pulse while busy is ignored
    wait_cfg = 1;
    run_op(mk(2'b11, 1, 0, 5'd10, 5'd11, 5'd13), 64'hF000_0000_0000_000F, 64'h68, 64'h0, 1);
    wait_cfg = 0;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R12", "pending expectations", 64'(q.size()), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule